// File: doc/BRIEF.md
# Lane-wise Leading-Bit Counter

This unit counts leading bits in every lane of a vector operand. Each lane holds one count, written into its low bits, and the rest of the lane is zero. There are two operations. Zero counting returns the number of zero bits at the top of the lane. Sign counting returns the number of bits directly below the lane's most significant bit that have the same value as that bit.

Lanes are 8, 16 or 32 bits wide, chosen by a two-bit size code. A width select picks either a 64-bit datapath or the full 128-bit datapath. In the 64-bit form, the upper half of the result is cleared.

The unit takes one operation per cycle. It registers its result, so each result appears one clock after the request. The size code value 3 is not a legal lane size; it raises an illegal flag and produces an all-zero result.

Top module: `lbc_vec_counter`

## Requirements
- R1: The result, illegal flag and valid output are registered. `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `result` and `illegal` update only on an accepted request and otherwise keep their value.
- R2: The lane width is 8 shifted left by `size_code`: code 0 gives 8-bit lanes, code 1 gives 16-bit lanes and code 2 gives 32-bit lanes. Lane i occupies bits [i*W+W-1 : i*W].
- R3: With `wide`=0, only operand bits 63:0 affect the result, and result bits 127:64 are zero. With `wide`=1, all 128 bits are processed.
- R4: With `zero_mode`=1, each lane's count is the number of consecutive zero bits starting at the lane's most significant bit. An all-zero lane gives the lane width.
- R5: With `zero_mode`=0, each lane's count is the number of consecutive bits below the lane's most significant bit that equal it. A lane of all zeros or all ones gives the lane width minus 1.
- R6: `size_code`=3 sets `illegal` to 1 and the whole result to zero. Any legal code clears `illegal`.
- R7: The count sits in the low bits of its lane as an unsigned number. All lane bits above the count are zero.
- R8: After synchronous reset, `out_valid`, `illegal` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; the operands are sampled in this cycle |
| operand | input | 128 | Vector operand |
| size_code | input | 2 | Lane size: 0 = 8, 1 = 16, 2 = 32, 3 = reserved |
| wide | input | 1 | 0 = 64-bit datapath, 1 = 128-bit datapath |
| zero_mode | input | 1 | 1 = leading-zero count, 0 = leading-sign count |
| out_valid | output | 1 | High in the cycle after an accepted request |
| result | output | 128 | Per-lane counts |
| illegal | output | 1 | High when the accepted request used size code 3 |

## Verification
Every result is due one clock edge after the request. The bench drives a request on a falling edge and drops `in_valid` on the next falling edge. It then compares `result`, `illegal` and `out_valid` at that second falling edge, which lies between the capturing edge and the edge that follows. A hold check leaves `in_valid` low for several more edges and confirms that the captured value stays put. Expected counts come from a bit-serial walk of each lane in the bench, done separately for the zero and sign forms. The stimulus covers all 256 byte values, the boundary patterns in every lane size, lane-by-lane staircases, and random operands with noise in the upper half.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

  typedef enum logic [1:0] {
    LSZ_8    = 2'd0,
    LSZ_16   = 2'd1,
    LSZ_32   = 2'd2,
    LSZ_RSVD = 2'd3
  } lane_size_e;

  localparam int NUM_LEGAL_SIZES = 3;

endpackage

// File: rtl/lbc_clz.sv
// Priority scan from the top bit: returns W when no bit is set.
module lbc_clz #(
  parameter int W  = 8,
  parameter int OW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [OW-1:0] count
);

  always_comb begin
    count = OW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) count = OW'(W - 1 - i);
    end
  end

  // R4: a count can never exceed the scanned width
  always_comb begin
    a_count_range_r4: assert (count <= OW'(W));
  end

endmodule

// File: rtl/lbc_lane.sv
// One lane: zero count directly, sign count as a zero count of the
// neighbour-difference bits below the top bit.
module lbc_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] lane_in,
  input  logic         zero_mode,
  output logic [W-1:0] lane_out
);

  localparam int CW = $clog2(W + 1);

  logic [W-2:0] diff;
  logic [CW-1:0] zc;
  logic [CW-1:0] sc;

  assign diff = lane_in[W-1:1] ^ lane_in[W-2:0];

  lbc_clz #(.W(W), .OW(CW)) u_zero (
    .vec   (lane_in),
    .count (zc)
  );

  lbc_clz #(.W(W - 1), .OW(CW)) u_sign (
    .vec   (diff),
    .count (sc)
  );

  always_comb begin
    lane_out = '0;
    lane_out[CW-1:0] = zero_mode ? zc : sc;
  end

  // R5: the sign count stays below the lane width
  always_comb begin
    a_sign_below_width_r5: assert (sc < CW'(W));
  end

endmodule

// File: rtl/lbc_lane_array.sv
module lbc_lane_array #(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 8
) (
  input  logic [VEC_W-1:0] operand,
  input  logic             zero_mode,
  output logic [VEC_W-1:0] result
);

  localparam int LANES = VEC_W / LANE_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lbc_lane #(.W(LANE_W)) u_lane (
      .lane_in   (operand[l*LANE_W +: LANE_W]),
      .zero_mode (zero_mode),
      .lane_out  (result[l*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/lbc_vec_counter.sv
module lbc_vec_counter
  import lbc_pkg::*;
#(
  parameter int VEC_W       = 128,
  parameter int BASE_LANE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] operand,
  input  logic [1:0]       size_code,
  input  logic             wide,
  input  logic             zero_mode,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic             illegal
);

  localparam int HALF_W = VEC_W / 2;

  logic [VEC_W-1:0] res_by_size [NUM_LEGAL_SIZES];
  logic [VEC_W-1:0] picked;
  logic [VEC_W-1:0] next_result;
  logic             rsvd;
  lane_size_e       sz;

  // One lane array per legal lane size; the size code picks among them.
  for (genvar k = 0; k < NUM_LEGAL_SIZES; k++) begin : g_size
    lbc_lane_array #(.VEC_W(VEC_W), .LANE_W(BASE_LANE_W << k)) u_arr (
      .operand   (operand),
      .zero_mode (zero_mode),
      .result    (res_by_size[k])
    );
  end

  assign sz = lane_size_e'(size_code);

  always_comb begin
    rsvd   = 1'b0;
    picked = '0;
    case (sz)
      LSZ_8:   picked = res_by_size[0];
      LSZ_16:  picked = res_by_size[1];
      LSZ_32:  picked = res_by_size[2];
      default: rsvd   = 1'b1;
    endcase
  end

  // Lanes never straddle the half boundary, so clearing the upper half
  // gives the narrow form.
  always_comb begin
    next_result = picked;
    if (!wide) next_result[VEC_W-1:HALF_W] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= next_result;
        illegal <= rsvd;
      end
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result) && $stable(illegal));

  p_narrow_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide) |=> (result[VEC_W-1:HALF_W] == '0));

  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_code == 2'd3) |=> (illegal && result == '0));

  p_legal_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_code != 2'd3) |=> !illegal);

endmodule

// File: tb/lbc_vec_counter_tb.sv
module lbc_vec_counter_tb;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [127:0] operand;
  logic [1:0]   size_code;
  logic         wide;
  logic         zero_mode;
  logic         out_valid;
  logic [127:0] result;
  logic         illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  lbc_vec_counter u_dut (
    .clk, .rst, .in_valid, .operand, .size_code,
    .wide, .zero_mode, .out_valid, .result, .illegal
  );

  // Bit-serial reference: walk each lane from its top bit.
  function automatic logic [127:0] model(logic [127:0] op, logic [1:0] sz,
                                         logic w, logic zm);
    logic [127:0] r = '0;
    int lw, n, c;
    logic s;
    if (sz == 2'd3) return r;
    lw = 8 << sz;
    n  = (w ? 128 : 64) / lw;
    for (int l = 0; l < n; l++) begin
      c = 0;
      if (zm) begin
        for (int b = lw - 1; b >= 0; b--) begin
          if (op[l*lw+b]) break;
          c++;
        end
      end else begin
        s = op[l*lw+lw-1];
        for (int b = lw - 2; b >= 0; b--) begin
          if (op[l*lw+b] != s) break;
          c++;
        end
      end
      for (int b = 0; b < lw; b++) r[l*lw+b] = (b < 32) ? c[b] : 1'b0;
    end
    return r;
  endfunction

  function automatic logic [127:0] fill(int lw, logic [31:0] lv);
    logic [127:0] r;
    for (int l = 0; l < 128 / lw; l++)
      for (int b = 0; b < lw; b++) r[l*lw+b] = lv[b];
    return r;
  endfunction

  function automatic logic [127:0] stair(int lw, int kind);
    logic [127:0] r;
    logic [32:0] ones;
    logic [32:0] lv;
    ones = (33'd1 << lw) - 33'd1;
    for (int l = 0; l < 128 / lw; l++) begin
      lv = ones >> (l % lw);
      if (kind != 0) lv = ~lv & ones;
      for (int b = 0; b < lw; b++) r[l*lw+b] = lv[b];
    end
    return r;
  endfunction

  function automatic string tag_of(logic [1:0] sz, logic w, logic zm);
    if (sz == 2'd3) return "R6";
    if (!w) return zm ? "R3/R4" : "R3/R5";
    return zm ? "R2/R4/R7" : "R2/R5/R7";
  endfunction

  task automatic run(input logic [127:0] op, input logic [1:0] sz,
                     input logic w, input logic zm);
    logic [127:0] exp;
    logic exp_ill;
    @(negedge clk);
    operand = op; size_code = sz; wide = w; zero_mode = zm; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp     = model(op, sz, w, zm);
    exp_ill = (sz == 2'd3);
    checks++;
    if (result !== exp || illegal !== exp_ill || out_valid !== 1'b1) begin
      fails++;
      $display("FAIL %s: result=%h illegal=%b valid=%b expected result=%h illegal=%b valid=1",
               tag_of(sz, w, zm), result, illegal, out_valid, exp, exp_ill);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    logic [32:0] ones;
    logic [127:0] snap;
    rst = 1'b1; in_valid = 1'b0; operand = '0;
    size_code = 2'd0; wide = 1'b0; zero_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    checks++;
    if (out_valid !== 1'b0 || illegal !== 1'b0 || result !== '0) begin
      fails++;
      $display("FAIL R8: valid=%b illegal=%b result=%h expected 0 0 0",
               out_valid, illegal, result);
    end

    // R2/R4/R5: boundary patterns in every lane width and both forms
    for (int sz = 0; sz < 3; sz++) begin
      int lw = 8 << sz;
      ones = (33'd1 << lw) - 33'd1;
      for (int w = 0; w < 2; w++) begin
        for (int zm = 0; zm < 2; zm++) begin
          run(fill(lw, 32'd0), 2'(sz), w[0], zm[0]);
          run(fill(lw, 32'(ones >> 1)), 2'(sz), w[0], zm[0]);
          run(fill(lw, 32'(33'd1 << (lw - 1))), 2'(sz), w[0], zm[0]);
          run(fill(lw, ones[31:0]), 2'(sz), w[0], zm[0]);
          run(stair(lw, 0), 2'(sz), w[0], zm[0]);
          run(stair(lw, 1), 2'(sz), w[0], zm[0]);
        end
      end
    end

    // R4/R5: every byte value in all 8-bit lanes
    for (int v = 0; v < 256; v++) begin
      run(fill(8, 32'(v)), 2'd0, 1'b1, 1'b1);
      run(fill(8, 32'(v)), 2'd0, 1'b1, 1'b0);
    end

    // R3: random operands, upper half carries noise in the narrow form
    for (int i = 0; i < 10; i++) begin
      for (int sz = 0; sz < 3; sz++) begin
        for (int w = 0; w < 2; w++) begin
          for (int zm = 0; zm < 2; zm++) begin
            logic [127:0] rv;
            rv = {$urandom(), $urandom(), $urandom(), $urandom()};
            rv = rv >> ($urandom() % 24);
            run(rv, 2'(sz), w[0], zm[0]);
          end
        end
      end
    end

    // R6: reserved size code, then a legal one clears the flag
    run('1, 2'd3, 1'b1, 1'b1);
    run(128'h0123_4567_89ab_cdef_0000_ffff_7f80_00ff, 2'd3, 1'b0, 1'b0);
    run('0, 2'd0, 1'b1, 1'b1);

    // R1: result holds while no request is made
    run(fill(16, 32'h0000_00f0), 2'd1, 1'b1, 1'b1);
    snap = result;
    operand = '1; size_code = 2'd3; zero_mode = 1'b0;
    repeat (4) @(negedge clk);
    checks++;
    if (result !== snap || illegal !== 1'b0 || out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: result=%h illegal=%b valid=%b expected result=%h illegal=0 valid=0",
               result, illegal, out_valid, snap);
    end

    done = 1;
    finish_run();
  end

endmodule